// File: doc/BRIEF.md
# Infrared Pulse Encoder and Decoder

This block sits between a UART and an infrared transceiver and converts between UART line levels and short light pulses. On the transmit side, the UART's bit stream arrives together with a strobe at the start of each bit. Every 0 bit is turned into a single pulse that begins half a bit period after the strobe. A 1 bit leaves the infrared output dark (low). The pulse length is programmable in half-periods of a selectable pulse clock, which reaches the block as a clock enable at twice that clock's rate.

On the receive side, the transceiver output is first polarity-corrected so that "light seen" becomes logic 1. It can then pass through a minimum-width filter that counts half-periods of the baud source clock. Each accepted pulse drives the rebuilt UART receive line low until one bit period has passed since the pulse's leading edge. When the master enable is cleared, both paths are bypassed and the UART levels pass straight through one register stage.

Baud generation and the UART are outside the block. The bit period, in system clock cycles, is supplied as a configuration input.

Top module: `ir_shim`

## Requirements
- R1: While reset is asserted, the cycle after it shows `ir_tx_pin` low and `uart_rx` high.
- R2: With the block enabled, a `uart_tx` level of 0 sampled on a `uart_tx_start` cycle raises `ir_tx_pin` exactly floor(B/2) clock cycles after that strobe edge, where B is `cfg_bit_cycles`. A sampled level of 1 produces no pulse during that bit.
- R3: A transmit pulse stays high for `cfg_tx_len`+1 ticks of the selected half-period pulse tick. With a tick on every cycle this is exactly `cfg_tx_len`+1 cycles.
- R4: The transmit pulse tick is `os_tick2x` only when both `cfg_tx_os_sel` and `cfg_os16_on` are 1. In every other case it is `br_tick2x`.
- R5: The receive light level is `ir_rx_pin` XOR `cfg_rx_inv`. When `cfg_rx_inv`=0 a high pin means light, and when it is 1 a low pin means light.
- R6: With the filter off (`cfg_rx_flt_en`=0), every rising edge of the light level drives `uart_rx` low from the next clock edge for exactly B cycles.
- R7: With the filter on, a pulse is accepted only once it has stayed lit for `cfg_rx_min`+4 consecutive `br_tick2x` ticks. `uart_rx` goes low at the edge of acceptance and returns high B cycles after the leading edge. A shorter pulse leaves `uart_rx` high.
- R8: With `cfg_en`=0, `ir_tx_pin` equals the previous cycle's `uart_tx` and `uart_rx` equals the previous cycle's `ir_rx_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Master enable; 0 bypasses encoder and decoder |
| cfg_tx_len | input | 6 | Transmit pulse length field (length = value+1 ticks) |
| cfg_tx_os_sel | input | 1 | Request the oversampled tick as transmit pulse clock |
| cfg_os16_on | input | 1 | Oversampling is active in the baud generator |
| cfg_rx_min | input | 6 | Receive filter field (minimum = value+4 ticks) |
| cfg_rx_inv | input | 1 | Receive polarity: 1 means the transceiver signals light with a low level |
| cfg_rx_flt_en | input | 1 | Receive minimum-width filter enable |
| cfg_bit_cycles | input | 16 | Bit period in clock cycles |
| br_tick2x | input | 1 | Enable at twice the baud source clock rate |
| os_tick2x | input | 1 | Enable at twice the 16x oversampled bit clock rate |
| uart_tx | input | 1 | UART transmit level |
| uart_tx_start | input | 1 | Strobe marking the start of each transmit bit |
| ir_rx_pin | input | 1 | Transceiver receive output |
| ir_tx_pin | output | 1 | Transceiver drive, high emits light |
| uart_rx | output | 1 | Rebuilt UART receive level |

## Verification
The assertions assume that `ir_rx_pin` is already synchronous to `clk` and that the configuration stays steady while a bit or pulse is in progress. They also assume that pulse length and filter length are smaller than the bit period. The stimulus changes configuration fields only while both lines are idle. It draws pulse lengths, filter lengths and receive pulse widths at random inside those bounds. It also drives the filter threshold exactly, one tick below and at the acceptance width.

// File: rtl/ir_shim_pkg.sv
package ir_shim_pkg;
  localparam int unsigned TX_LEN_OFFSET = 1;
  localparam int unsigned RX_MIN_OFFSET = 4;

  function automatic logic lit_level(input logic pin, input logic inv);
    return pin ^ inv;
  endfunction
endpackage

// File: rtl/ir_tx_pulser.sv
module ir_tx_pulser #(
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned BIT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tx_bit,
  input  logic               bit_start,
  input  logic               tick_br,
  input  logic               tick_os,
  input  logic               os_sel,
  input  logic               os_on,
  input  logic [FIELD_W-1:0] pulse_len,
  input  logic [BIT_W-1:0]   bit_cycles,
  output logic               ir_tx
);
  logic               tick, fire;
  logic               armed, armed_n, pulsing, pulsing_n;
  logic [BIT_W-1:0]   mid, mid_n;
  logic [FIELD_W-1:0] plc, plc_n;

  always_comb begin
    tick      = (os_sel && os_on) ? tick_os : tick_br;
    armed_n   = armed;
    mid_n     = mid;
    pulsing_n = pulsing;
    plc_n     = plc;
    fire      = armed && !bit_start && (mid <= BIT_W'(1));
    if (bit_start) begin
      armed_n = ~tx_bit;
      mid_n   = bit_cycles >> 1;
    end else if (fire) begin
      armed_n = 1'b0;
    end else if (armed) begin
      mid_n = mid - 1'b1;
    end
    if (fire) begin
      pulsing_n = 1'b1;
      plc_n     = '0;
    end else if (pulsing && tick) begin
      if (plc == pulse_len) pulsing_n = 1'b0;
      else                  plc_n     = plc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      mid     <= '0;
      pulsing <= 1'b0;
      plc     <= '0;
      ir_tx   <= 1'b0;
    end else if (!en) begin
      armed   <= 1'b0;
      mid     <= '0;
      pulsing <= 1'b0;
      plc     <= '0;
      ir_tx   <= tx_bit;
    end else begin
      armed   <= armed_n;
      mid     <= mid_n;
      pulsing <= pulsing_n;
      plc     <= plc_n;
      ir_tx   <= pulsing_n;
    end
  end
endmodule

// File: rtl/ir_rx_shaper.sv
module ir_rx_shaper #(
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned BIT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               rx_pin,
  input  logic               inv,
  input  logic               flt_en,
  input  logic [FIELD_W-1:0] flt_len,
  input  logic               tick_br,
  input  logic [BIT_W-1:0]   bit_cycles,
  output logic               rx_out
);
  import ir_shim_pkg::*;
  localparam int unsigned WID_W = FIELD_W + 1;

  logic             lit, lit_q, rise;
  logic             win, win_n, acc, acc_n;
  logic [BIT_W-1:0] age, age_n;
  logic [WID_W-1:0] wid, wid_n, thr;

  always_comb begin
    lit   = lit_level(rx_pin, inv);
    rise  = lit && !lit_q;
    thr   = {1'b0, flt_len} + WID_W'(RX_MIN_OFFSET);
    win_n = win;
    acc_n = acc;
    age_n = age;
    wid_n = wid;
    if (rise) begin
      win_n = 1'b1;
      age_n = BIT_W'(1);
      wid_n = tick_br ? WID_W'(1) : '0;
      acc_n = !flt_en;
    end else begin
      if (win && (age == bit_cycles)) begin
        win_n = 1'b0;
        acc_n = 1'b0;
      end else if (win) begin
        age_n = age + 1'b1;
      end
      if (!lit)                        wid_n = '0;
      else if (tick_br && (wid != '1)) wid_n = wid + 1'b1;
      if (lit && win_n && (wid_n >= thr)) acc_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lit_q  <= 1'b0;
      win    <= 1'b0;
      acc    <= 1'b0;
      age    <= '0;
      wid    <= '0;
      rx_out <= 1'b1;
    end else if (!en) begin
      lit_q  <= lit;
      win    <= 1'b0;
      acc    <= 1'b0;
      age    <= '0;
      wid    <= '0;
      rx_out <= rx_pin;
    end else begin
      lit_q  <= lit;
      win    <= win_n;
      acc    <= acc_n;
      age    <= age_n;
      wid    <= wid_n;
      rx_out <= !(acc_n && win_n);
    end
  end
endmodule

// File: rtl/ir_shim.sv
module ir_shim #(
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned BIT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic [FIELD_W-1:0] cfg_tx_len,
  input  logic               cfg_tx_os_sel,
  input  logic               cfg_os16_on,
  input  logic [FIELD_W-1:0] cfg_rx_min,
  input  logic               cfg_rx_inv,
  input  logic               cfg_rx_flt_en,
  input  logic [BIT_W-1:0]   cfg_bit_cycles,
  input  logic               br_tick2x,
  input  logic               os_tick2x,
  input  logic               uart_tx,
  input  logic               uart_tx_start,
  input  logic               ir_rx_pin,
  output logic               ir_tx_pin,
  output logic               uart_rx
);
  ir_tx_pulser #(.FIELD_W(FIELD_W), .BIT_W(BIT_W)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_en),
    .tx_bit    (uart_tx),
    .bit_start (uart_tx_start),
    .tick_br   (br_tick2x),
    .tick_os   (os_tick2x),
    .os_sel    (cfg_tx_os_sel),
    .os_on     (cfg_os16_on),
    .pulse_len (cfg_tx_len),
    .bit_cycles(cfg_bit_cycles),
    .ir_tx     (ir_tx_pin)
  );

  ir_rx_shaper #(.FIELD_W(FIELD_W), .BIT_W(BIT_W)) rx_i (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_en),
    .rx_pin    (ir_rx_pin),
    .inv       (cfg_rx_inv),
    .flt_en    (cfg_rx_flt_en),
    .flt_len   (cfg_rx_min),
    .tick_br   (br_tick2x),
    .bit_cycles(cfg_bit_cycles),
    .rx_out    (uart_rx)
  );
endmodule

// File: rtl/ir_shim_chk.sv
module ir_shim_chk (
  input logic clk,
  input logic rst,
  input logic cfg_en,
  input logic cfg_rx_inv,
  input logic cfg_rx_flt_en,
  input logic uart_tx,
  input logic ir_rx_pin,
  input logic ir_tx_pin,
  input logic uart_rx
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!ir_tx_pin && uart_rx)); // R1

  AST_BYPASS_TX: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (ir_tx_pin == $past(uart_tx))); // R8

  AST_BYPASS_RX: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (uart_rx == $past(ir_rx_pin))); // R8

  AST_UNFILTERED_LOW: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !cfg_rx_flt_en && $rose(ir_rx_pin ^ cfg_rx_inv)) |=> !uart_rx); // R6

  AST_FILTER_NEEDS_LIGHT: assert property (@(posedge clk) disable iff (rst)
    ($fell(uart_rx) && $past(cfg_en && cfg_rx_flt_en)) |-> $past(ir_rx_pin ^ cfg_rx_inv)); // R7
endmodule

bind ir_shim ir_shim_chk chk_i (.*);

// File: tb/ir_shim_tb_top.sv
module ir_shim_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0;
  logic [5:0]  cfg_tx_len = '0;
  logic        cfg_tx_os_sel = 1'b0;
  logic        cfg_os16_on = 1'b0;
  logic [5:0]  cfg_rx_min = '0;
  logic        cfg_rx_inv = 1'b0;
  logic        cfg_rx_flt_en = 1'b0;
  logic [15:0] cfg_bit_cycles = 16'd40;
  logic        br_tick2x = 1'b1;
  logic        os_tick2x = 1'b0;
  logic        uart_tx = 1'b1;
  logic        uart_tx_start = 1'b0;
  logic        ir_rx_pin = 1'b0;
  logic        ir_tx_pin, uart_rx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit os_alt = 1'b0;

  always #2ns clk = ~clk;

  always @(negedge clk) if (os_alt) os_tick2x = ~os_tick2x; else os_tick2x = 1'b0;

  ir_shim dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_rx(input int j, input int w, input int bc, input int fl, input bit flt);
    if (j >= bc) return 1'b1;
    if (!flt) return 1'b0;
    return !((w >= fl + 4) && (j >= fl + 3));
  endfunction

  // one UART bit; alt: tick every second cycle
  task automatic send_bit(input logic b, input int bc, input int pl, input bit alt, input string req);
    int first, n;
    @(negedge clk); uart_tx = b; uart_tx_start = 1'b1;
    @(negedge clk); uart_tx_start = 1'b0;
    first = -1; n = 0;
    for (int i = 0; i < bc; i++) begin
      if (ir_tx_pin) begin n++; if (first < 0) first = i; end
      @(negedge clk);
    end
    if (b) chk(n == 0, "R2 one bit dark", n, 0);
    else begin
      chk(first == bc / 2, "R2 pulse start", first, bc / 2);
      if (alt) chk(n == 2*pl+1 || n == 2*pl+2, req, n, 2*pl+2);
      else     chk(n == pl + 1, req, n, pl + 1);
    end
  endtask

  // lit pulse of w cycles; window of bc+4 observations
  task automatic rx_pulse(input int w, input int bc, input int fl, input bit flt, input string req);
    int bad, first_act, first_exp;
    bad = 0; first_act = 0; first_exp = 0;
    @(negedge clk); ir_rx_pin = ~cfg_rx_inv;
    for (int j = 0; j < bc + 4; j++) begin
      @(negedge clk);
      if (uart_rx != exp_rx(j, w, bc, fl, flt)) begin
        if (bad == 0) begin first_act = 1000*j + int'(uart_rx); first_exp = 1000*j + int'(exp_rx(j, w, bc, fl, flt)); end
        bad++;
      end
      ir_rx_pin = (j + 1 < w) ? ~cfg_rx_inv : cfg_rx_inv;
    end
    chk(bad == 0, req, first_act, first_exp);
  endtask

  initial begin
    int unsigned s;
    int bc, pl, fl, w;
    bit flt;
    s = $urandom(32'd7731);
    repeat (3) @(negedge clk);
    chk(ir_tx_pin == 1'b0, "R1 ir_tx_pin", int'(ir_tx_pin), 0);
    chk(uart_rx == 1'b1, "R1 uart_rx", int'(uart_rx), 1);
    rst = 1'b0;
    cfg_en = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3: tick every cycle, random bits
    for (int k = 0; k < 4; k++) begin
      bc = 30 + int'($urandom_range(0, 31));
      pl = int'($urandom_range(0, 9));
      cfg_bit_cycles = 16'(bc); cfg_tx_len = 6'(pl);
      send_bit(1'b0, bc, pl, 1'b0, "R3 pulse width");
      for (int i = 0; i < 6; i++) send_bit(logic'($urandom_range(0, 1)), bc, pl, 1'b0, "R3 pulse width");
    end
    // R4 selections
    bc = 48; cfg_bit_cycles = 16'(bc);
    pl = 5; cfg_tx_len = 6'(pl);
    os_alt = 1'b1;
    cfg_tx_os_sel = 1'b1; cfg_os16_on = 1'b0;
    send_bit(1'b0, bc, pl, 1'b0, "R4 os sel ignored without oversampling");
    cfg_tx_os_sel = 1'b0; cfg_os16_on = 1'b1;
    send_bit(1'b0, bc, pl, 1'b0, "R4 baud tick when not selected");
    cfg_tx_os_sel = 1'b1; cfg_os16_on = 1'b1;
    for (int i = 0; i < 4; i++) begin
      pl = int'($urandom_range(0, 9)); cfg_tx_len = 6'(pl);
      send_bit(1'b0, bc, pl, 1'b1, "R4 R3 oversampled tick width");
    end
    pl = 0; cfg_tx_len = '0;
    send_bit(1'b0, bc, pl, 1'b1, "R4 R3 shortest oversampled pulse");
    os_alt = 1'b0; cfg_tx_os_sel = 1'b0; cfg_os16_on = 1'b0;
    @(negedge clk); uart_tx = 1'b1;

    // receive: R5 R6 R7
    bc = 50; cfg_bit_cycles = 16'(bc);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      cfg_rx_inv = logic'($urandom_range(0, 1));
      ir_rx_pin = cfg_rx_inv;
      flt = bit'($urandom_range(0, 1));
      fl = int'($urandom_range(0, 20));
      w = 1 + int'($urandom_range(0, 29));
      cfg_rx_flt_en = flt; cfg_rx_min = 6'(fl);
      rx_pulse(w, bc, fl, flt, flt ? "R7 R5 random filtered pulse" : "R6 R5 random unfiltered pulse");
    end
    @(negedge clk);
    cfg_rx_inv = 1'b1; ir_rx_pin = 1'b1; cfg_rx_flt_en = 1'b1; fl = 6; cfg_rx_min = 6'(fl);
    rx_pulse(fl + 3, bc, fl, 1'b1, "R7 one tick short rejected");
    rx_pulse(fl + 4, bc, fl, 1'b1, "R7 exact threshold accepted");
    @(negedge clk);
    cfg_rx_inv = 1'b0; ir_rx_pin = 1'b0; cfg_rx_flt_en = 1'b0;
    rx_pulse(1, bc, fl, 1'b0, "R6 single cycle unfiltered");
    @(negedge clk);
    fl = 63; cfg_rx_min = 6'(fl); cfg_rx_flt_en = 1'b1; bc = 120; cfg_bit_cycles = 16'(bc);
    rx_pulse(66, bc, fl, 1'b1, "R7 max filter short rejected");
    rx_pulse(67, bc, fl, 1'b1, "R7 max filter accepted");

    // R8 bypass
    @(negedge clk);
    cfg_en = 1'b0; uart_tx = 1'b0; ir_rx_pin = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic pt, pr;
      pt = uart_tx; pr = ir_rx_pin;
      @(negedge clk);
      chk(ir_tx_pin == pt, "R8 bypass tx", int'(ir_tx_pin), int'(pt));
      chk(uart_rx == pr, "R8 bypass rx", int'(uart_rx), int'(pr));
      uart_tx = logic'($urandom_range(0, 1));
      ir_rx_pin = logic'($urandom_range(0, 1));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule